// File: doc/BRIEF.md
# Power-On Strap Latch and CPU Frequency Select

This block captures the frequency-select strap levels when a single shared pin indicates that power is good. It then decides whether the clock generator runs in normal operation or in a test mode. After the capture, the same pin is reinterpreted as a live, active-high power-down request. The captured strap code is decoded into a CPU frequency in MHz, a multiplier N and a resolution step. N times the step gives the CPU frequency. When multiplier programming is enabled, register-supplied CPU and SRC multipliers replace the defaults.

The shared pin idles high before power is good. Its first synchronized low level after reset is the capture strobe. From then on a high level requests power-down. The strap code is `{c,b,a}`. A separate input, `strap_test_lvl`, reports whether the C strap was driven above the test threshold when it was sampled; comparing the pin against that threshold is done outside this block. A software test-mode request can also select one of the two test output states.

Top module: `fsel_strap_ctl`

## Requirements
- R1: After reset `straps_valid` is 0. On the first clock where the synchronized `pg_pd_n` is low, `{strap_c,strap_b,strap_a}` and `strap_test_lvl` are captured, and `straps_valid` becomes 1 and stays 1 until reset.
- R2: Once `straps_valid` is 1, later changes of the strap inputs change neither `straps_q`, `test_strap_q` nor the decoded outputs.
- R3: `pwr_down` is 0 while `straps_valid` is 0. After the capture it follows the synchronized `pg_pd_n` level, where high means power-down.
- R4: The code `{c,b,a}` decodes to `cpu_mhz` as follows: 000=266, 001=133, 010=200, 011=166, 100=333, 101=100, 110=400. Code 111 is reserved and gives `cpu_mhz`=0 with `freq_ok`=0. Every other code gives `freq_ok`=1.
- R5: With `nprog_en`=0, `cpu_n`/`res_code` are 150/2 for 100 MHz, 200/2 for 133, 125/4 for 166, 150/4 for 200, 200/4 for 266, 125/8 for 333 and 150/8 for 400, and 0/0 for the reserved code. `res_code` counts thirds of a MHz, and floor(`cpu_n`*`res_code`/3) equals `cpu_mhz`. `src_n` is 150.
- R6: With `nprog_en`=1, `cpu_n` equals `cpu_n_reg` and `src_n` equals `src_n_reg`. `cpu_mhz` and `res_code` are unchanged.
- R7: If `test_strap_q` is 1, the block is in test mode (`test_active`=1). `out_mode` is 1 (outputs high-impedance) when the captured B strap is 0, and 2 (outputs drive ref/N) when it is 1.
- R8: If `test_strap_q` is 0 and `sw_test_en` is 1, `test_active`=1 and `out_mode` is 2 when `sw_test_refn`=1 and 1 otherwise. A strap-selected test mode takes precedence over the software bits.
- R9: With no test mode active, `out_mode` is 0 (normal) and `test_active`=0. `out_mode` never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pg_pd_n | input | 1 | Shared pin: low is the capture strobe before capture, high requests power-down after capture |
| strap_a | input | 1 | Frequency strap A |
| strap_b | input | 1 | Frequency strap B, which also picks the test output state |
| strap_c | input | 1 | Frequency strap C |
| strap_test_lvl | input | 1 | C strap was driven above the test threshold |
| nprog_en | input | 1 | Use the register multipliers |
| cpu_n_reg | input | 8 | Register CPU multiplier |
| src_n_reg | input | 8 | Register SRC multiplier |
| sw_test_en | input | 1 | Software test-mode request |
| sw_test_refn | input | 1 | Software test state: 1 ref/N, 0 high-impedance |
| straps_valid | output | 1 | Straps have been captured |
| straps_q | output | 3 | Captured `{c,b,a}` |
| test_strap_q | output | 1 | Captured test-level flag |
| pwr_down | output | 1 | Live power-down request |
| cpu_mhz | output | 10 | Selected CPU frequency in MHz, 0 if reserved |
| freq_ok | output | 1 | Code is not reserved |
| cpu_n | output | 8 | Effective CPU multiplier |
| src_n | output | 8 | Effective SRC multiplier |
| res_code | output | 4 | Resolution step in thirds of a MHz |
| test_active | output | 1 | A test mode is active |
| out_mode | output | 2 | 0 normal, 1 high-impedance, 2 ref/N |

## Verification
The assertions assume that the strap inputs are quasi-static. They assume that `nprog_en` is held low through reset and only changes once reset has been released. They also assume that `pg_pd_n` starts high, so the capture happens after reset and not during it. The stimulus resets the block before each strap pattern and holds `nprog_en` constant for the whole pattern. It drives the pin high before reset is released. Only after the straps have settled does it pull the pin low.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

  localparam int FREQ_W = 10;
  localparam int N_W    = 8;
  localparam int RES_W  = 4;
  localparam int CODE_W = 3;

  typedef enum logic [1:0] {
    OUT_NORMAL = 2'd0,
    OUT_HIZ    = 2'd1,
    OUT_REFN   = 2'd2
  } out_mode_e;

  typedef struct packed {
    logic tst;
    logic c;
    logic b;
    logic a;
  } strap_t;

  typedef struct packed {
    logic [FREQ_W-1:0] mhz;
    logic [N_W-1:0]    n;
    logic [RES_W-1:0]  res;
    logic              ok;
  } fsel_entry_t;

  // Resolution is carried in thirds of a MHz: 2 -> 0.667, 4 -> 1.333, 8 -> 2.667.
  function automatic fsel_entry_t fsel_lookup(input logic [CODE_W-1:0] code);
    fsel_entry_t e;
    e = '0;
    unique case (code)
      3'b101: begin e.mhz = 10'd100; e.n = 8'd150; e.res = 4'd2; e.ok = 1'b1; end
      3'b001: begin e.mhz = 10'd133; e.n = 8'd200; e.res = 4'd2; e.ok = 1'b1; end
      3'b011: begin e.mhz = 10'd166; e.n = 8'd125; e.res = 4'd4; e.ok = 1'b1; end
      3'b010: begin e.mhz = 10'd200; e.n = 8'd150; e.res = 4'd4; e.ok = 1'b1; end
      3'b000: begin e.mhz = 10'd266; e.n = 8'd200; e.res = 4'd4; e.ok = 1'b1; end
      3'b100: begin e.mhz = 10'd333; e.n = 8'd125; e.res = 4'd8; e.ok = 1'b1; end
      3'b110: begin e.mhz = 10'd400; e.n = 8'd150; e.res = 4'd8; e.ok = 1'b1; end
      default: e = '0;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/fsel_sync.sv
module fsel_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RST_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fsel_strap_latch.sv
module fsel_strap_latch
  import fsel_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   pin_s,
  input  strap_t strap_in,
  output strap_t straps_q,
  output logic   valid_q,
  output logic   pwr_down_q
);
  logic capture;

  // The strobe is level sensitive and only acts once per reset.
  assign capture = ~valid_q & ~pin_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      straps_q   <= '0;
      valid_q    <= 1'b0;
      pwr_down_q <= 1'b0;
    end else begin
      if (capture) begin
        straps_q <= strap_in;
        valid_q  <= 1'b1;
      end
      // After capture the pin is a live active-high power-down request.
      pwr_down_q <= valid_q & pin_s;
    end
  end
endmodule

// File: rtl/fsel_decode.sv
module fsel_decode
  import fsel_pkg::*;
#(
  parameter logic [N_W-1:0] SRC_N_DEF = 8'd150
) (
  input  logic              clk,
  input  logic              rst,
  input  strap_t            straps,
  input  logic              nprog_en,
  input  logic [N_W-1:0]    cpu_n_reg,
  input  logic [N_W-1:0]    src_n_reg,
  output logic [FREQ_W-1:0] cpu_mhz,
  output logic              freq_ok,
  output logic [N_W-1:0]    cpu_n,
  output logic [N_W-1:0]    src_n,
  output logic [RES_W-1:0]  res_code
);
  fsel_entry_t ent;

  always_comb ent = fsel_lookup({straps.c, straps.b, straps.a});

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_mhz  <= '0;
      freq_ok  <= 1'b0;
      cpu_n    <= '0;
      src_n    <= '0;
      res_code <= '0;
    end else begin
      cpu_mhz  <= ent.mhz;
      freq_ok  <= ent.ok;
      res_code <= ent.res;
      cpu_n    <= nprog_en ? cpu_n_reg : ent.n;
      src_n    <= nprog_en ? src_n_reg : SRC_N_DEF;
    end
  end
endmodule

// File: rtl/fsel_testmode.sv
module fsel_testmode
  import fsel_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  strap_t     straps,
  input  logic       valid,
  input  logic       sw_test_en,
  input  logic       sw_test_refn,
  output logic       test_active,
  output logic [1:0] out_mode
);
  logic      hw_test;
  out_mode_e mode_d;

  assign hw_test = valid & straps.tst;

  always_comb begin
    if (hw_test)         mode_d = straps.b ? OUT_REFN : OUT_HIZ;
    else if (sw_test_en) mode_d = sw_test_refn ? OUT_REFN : OUT_HIZ;
    else                 mode_d = OUT_NORMAL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      test_active <= 1'b0;
      out_mode    <= OUT_NORMAL;
    end else begin
      test_active <= hw_test | sw_test_en;
      out_mode    <= mode_d;
    end
  end
endmodule

// File: rtl/fsel_strap_ctl.sv
module fsel_strap_ctl
  import fsel_pkg::*;
#(
  parameter int              SYNC_STAGES = 2,
  parameter logic [N_W-1:0]  SRC_N_DEF   = 8'd150
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pg_pd_n,
  input  logic              strap_a,
  input  logic              strap_b,
  input  logic              strap_c,
  input  logic              strap_test_lvl,
  input  logic              nprog_en,
  input  logic [N_W-1:0]    cpu_n_reg,
  input  logic [N_W-1:0]    src_n_reg,
  input  logic              sw_test_en,
  input  logic              sw_test_refn,
  output logic              straps_valid,
  output logic [CODE_W-1:0] straps_q,
  output logic              test_strap_q,
  output logic              pwr_down,
  output logic [FREQ_W-1:0] cpu_mhz,
  output logic              freq_ok,
  output logic [N_W-1:0]    cpu_n,
  output logic [N_W-1:0]    src_n,
  output logic [RES_W-1:0]  res_code,
  output logic              test_active,
  output logic [1:0]        out_mode
);
  logic   pin_s;
  strap_t strap_in;
  strap_t straps_r;

  assign strap_in = '{tst: strap_test_lvl, c: strap_c, b: strap_b, a: strap_a};

  fsel_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(pg_pd_n), .q(pin_s)
  );

  fsel_strap_latch u_latch (
    .clk(clk), .rst(rst), .pin_s(pin_s), .strap_in(strap_in),
    .straps_q(straps_r), .valid_q(straps_valid), .pwr_down_q(pwr_down)
  );

  fsel_decode #(.SRC_N_DEF(SRC_N_DEF)) u_decode (
    .clk(clk), .rst(rst), .straps(straps_r), .nprog_en(nprog_en),
    .cpu_n_reg(cpu_n_reg), .src_n_reg(src_n_reg),
    .cpu_mhz(cpu_mhz), .freq_ok(freq_ok), .cpu_n(cpu_n), .src_n(src_n),
    .res_code(res_code)
  );

  fsel_testmode u_test (
    .clk(clk), .rst(rst), .straps(straps_r), .valid(straps_valid),
    .sw_test_en(sw_test_en), .sw_test_refn(sw_test_refn),
    .test_active(test_active), .out_mode(out_mode)
  );

  assign straps_q     = {straps_r.c, straps_r.b, straps_r.a};
  assign test_strap_q = straps_r.tst;
endmodule

// File: rtl/fsel_strap_chk.sv
module fsel_strap_chk (
  input logic       clk,
  input logic       rst,
  input logic       nprog_en,
  input logic       straps_valid,
  input logic [2:0] straps_q,
  input logic       test_strap_q,
  input logic       pwr_down,
  input logic [9:0] cpu_mhz,
  input logic       freq_ok,
  input logic [7:0] cpu_n,
  input logic [3:0] res_code,
  input logic       test_active,
  input logic [1:0] out_mode
);
  logic [11:0] prod;
  always_comb prod = {4'b0, cpu_n} * {8'b0, res_code};

  a_r1_valid_sticky: assert property (@(posedge clk) disable iff (rst)
    straps_valid |=> straps_valid);

  a_r2_straps_hold: assert property (@(posedge clk) disable iff (rst)
    (straps_valid && $past(straps_valid)) |-> ($stable(straps_q) && $stable(test_strap_q)));

  a_r3_no_pd_early: assert property (@(posedge clk) disable iff (rst)
    !straps_valid |-> !pwr_down);

  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    !freq_ok |-> (cpu_mhz == 10'd0 && res_code == 4'd0));

  a_r5_n_times_res: assert property (@(posedge clk) disable iff (rst)
    (freq_ok && !nprog_en && !$past(nprog_en)) |-> ((prod / 12'd3) == {2'b0, cpu_mhz}));

  a_r9_mode_legal: assert property (@(posedge clk) disable iff (rst)
    out_mode != 2'd3);

  a_r9_mode_matches_active: assert property (@(posedge clk) disable iff (rst)
    (out_mode == 2'd0) == !test_active);
endmodule

bind fsel_strap_ctl fsel_strap_chk u_chk (
  .clk(clk), .rst(rst), .nprog_en(nprog_en), .straps_valid(straps_valid),
  .straps_q(straps_q), .test_strap_q(test_strap_q), .pwr_down(pwr_down),
  .cpu_mhz(cpu_mhz), .freq_ok(freq_ok), .cpu_n(cpu_n), .res_code(res_code),
  .test_active(test_active), .out_mode(out_mode)
);

// File: tb/fsel_strap_ctl_bench.sv
module fsel_strap_ctl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pg_pd_n = 1'b1;
  logic       strap_a = 1'b0, strap_b = 1'b0, strap_c = 1'b0, strap_test_lvl = 1'b0;
  logic       nprog_en = 1'b0;
  logic [7:0] cpu_n_reg = 8'h96, src_n_reg = 8'h96;
  logic       sw_test_en = 1'b0, sw_test_refn = 1'b0;
  logic       straps_valid, test_strap_q, pwr_down, freq_ok, test_active;
  logic [2:0] straps_q;
  logic [9:0] cpu_mhz;
  logic [7:0] cpu_n, src_n;
  logic [3:0] res_code;
  logic [1:0] out_mode;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  fsel_strap_ctl u_fsel_strap_ctl (
    .clk(clk), .rst(rst), .pg_pd_n(pg_pd_n), .strap_a(strap_a), .strap_b(strap_b),
    .strap_c(strap_c), .strap_test_lvl(strap_test_lvl), .nprog_en(nprog_en),
    .cpu_n_reg(cpu_n_reg), .src_n_reg(src_n_reg), .sw_test_en(sw_test_en),
    .sw_test_refn(sw_test_refn), .straps_valid(straps_valid), .straps_q(straps_q),
    .test_strap_q(test_strap_q), .pwr_down(pwr_down), .cpu_mhz(cpu_mhz),
    .freq_ok(freq_ok), .cpu_n(cpu_n), .src_n(src_n), .res_code(res_code),
    .test_active(test_active), .out_mode(out_mode)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_mhz(input int code);
    case (code)
      5: return 100; 1: return 133; 3: return 166; 2: return 200;
      0: return 266; 4: return 333; 6: return 400; default: return 0;
    endcase
  endfunction

  function automatic int exp_res(input int mhz);
    if (mhz == 0) return 0;
    if (mhz <= 133) return 2;
    if (mhz <= 266) return 4;
    return 8;
  endfunction

  // Smallest N whose product with the step, floored in MHz, gives the frequency.
  function automatic int exp_n(input int mhz);
    int r;
    r = exp_res(mhz);
    if (r == 0) return 0;
    for (int n = 1; n < 256; n++) if ((n * r) / 3 == mhz) return n;
    return -1;
  endfunction

  function automatic int exp_mode(input bit tst, input bit b, input bit swe, input bit swr);
    if (tst) return b ? 2 : 1;
    if (swe) return swr ? 2 : 1;
    return 0;
  endfunction

  task automatic run_pattern(input int pat, input bit np);
    int  code;
    bit  tst;
    int  m;
    code = pat & 7;
    tst  = pat[3];
    m    = exp_mhz(code);
    @(negedge clk);
    rst = 1'b1; pg_pd_n = 1'b1; sw_test_en = 1'b0; sw_test_refn = 1'b0;
    nprog_en = np;
    cpu_n_reg = 8'h96 ^ 8'(pat * 17);
    src_n_reg = 8'h3c + 8'(pat);
    {strap_c, strap_b, strap_a} = 3'(code);
    strap_test_lvl = tst;
    cyc(3);
    rst = 1'b0;
    cyc(5);
    // R1 / R3: nothing captured, no power-down while the pin is still high
    chk(straps_valid == 1'b0, "R1 reset/valid", straps_valid, 0);
    chk(pwr_down == 1'b0, "R3 pd before capture", pwr_down, 0);
    chk(out_mode == 2'd0, "R9 mode before capture", out_mode, 0);
    pg_pd_n = 1'b0;
    cyc(6);
    chk(straps_valid == 1'b1, "R1 valid", straps_valid, 1);
    chk(straps_q == 3'(code), "R1 straps", straps_q, code);
    chk(test_strap_q == tst, "R1 test strap", test_strap_q, tst);
    chk(cpu_mhz == 10'(m), "R4 mhz", cpu_mhz, m);
    chk(freq_ok == (m != 0), "R4 ok", freq_ok, m != 0);
    chk(res_code == 4'(exp_res(m)), "R5 res", res_code, exp_res(m));
    if (np) begin
      chk(cpu_n == cpu_n_reg, "R6 cpu n", cpu_n, cpu_n_reg);
      chk(src_n == src_n_reg, "R6 src n", src_n, src_n_reg);
    end else begin
      chk(cpu_n == 8'(exp_n(m)), "R5 cpu n", cpu_n, exp_n(m));
      chk(src_n == 8'd150, "R5 src n", src_n, 150);
    end
    chk(out_mode == 2'(exp_mode(tst, code[1], 0, 0)),
        tst ? "R7 strap test mode" : "R9 normal mode", out_mode, exp_mode(tst, code[1], 0, 0));
    chk(test_active == tst, "R7/R9 test active", test_active, tst);
    // R2: strap changes after capture are ignored
    {strap_c, strap_b, strap_a} = ~3'(code);
    strap_test_lvl = ~tst;
    cyc(6);
    chk(straps_q == 3'(code), "R2 straps held", straps_q, code);
    chk(test_strap_q == tst, "R2 test held", test_strap_q, tst);
    chk(cpu_mhz == 10'(m), "R2 mhz held", cpu_mhz, m);
    chk(out_mode == 2'(exp_mode(tst, code[1], 0, 0)), "R2 mode held", out_mode,
        exp_mode(tst, code[1], 0, 0));
    // R3: pin is now a live power-down request
    pg_pd_n = 1'b1;
    cyc(5);
    chk(pwr_down == 1'b1, "R3 pd high", pwr_down, 1);
    chk(straps_q == 3'(code), "R2 straps held over pd", straps_q, code);
    pg_pd_n = 1'b0;
    cyc(5);
    chk(pwr_down == 1'b0, "R3 pd low", pwr_down, 0);
    // R8: software test entry, with strap precedence
    for (int s = 0; s < 4; s++) begin
      sw_test_en = s[1]; sw_test_refn = s[0];
      cyc(3);
      chk(out_mode == 2'(exp_mode(tst, code[1], s[1], s[0])), "R8 sw test mode", out_mode,
          exp_mode(tst, code[1], s[1], s[0]));
      chk(test_active == (tst | s[1]), "R8 sw test active", test_active, tst | s[1]);
    end
  endtask

  initial begin
    cyc(2);
    chk(straps_valid == 1'b0, "R1 reset", straps_valid, 0);
    chk(pwr_down == 1'b0, "R3 reset", pwr_down, 0);
    for (int np = 0; np < 2; np++)
      for (int p = 0; p < 16; p++)
        run_pattern(p, np[0]);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule